// File: doc/BRIEF.md
# Xon/Xoff Receive Flow Matcher

This block sits in a UART receive path, after a character has been assembled and before it reaches the receive FIFO. It compares each incoming character with four programmable flow-control characters: two for resume and two for suspend. The comparison uses only as many low bits as the programmed word length selects. A match of the suspend character(s) raises a level that tells the transmitter to stop after the character it is currently sending. While suspended, the block looks for the resume character(s), and a match drops that level again. Characters used up as flow control never reach the FIFO.

There are four modes. Off passes everything. Single mode matches one character. Double mode needs two consecutive characters. In double mode the first character of a possible pair is held back. If the pair does not complete, the held character is released to the FIFO, followed one cycle later by the second character. That second character is also checked again as the possible start of a new pair. Special-character mode does no flow control. It only flags arrivals of the second suspend character, and still passes that character to the FIFO.

A status flag records flow-control events and special-character arrivals. It drives an interrupt output through an enable. A status read clears the flag unless a match lands in the same cycle.

Top module: `xonxoff_rx_matcher`

## Requirements
- R1: One cycle after a cycle with `rst` high, `tx_suspend`, `flag`, `irq` and `fifo_we` are 0 and all four X-registers are zero, so a received 0x00 matches them.
- R2: A `cfg_we` pulse writes `cfg_wdata` to the X-register chosen by `cfg_addr`: 0 first resume, 1 second resume, 2 first suspend, 3 second suspend.
- R3: In single mode (`fc_mode`=1), a character that matches the first suspend register while not suspended sets `tx_suspend` and is not written. A non-matching character appears unchanged on `fifo_data` with `fifo_we` high in the cycle after its `rx_valid`.
- R4: In single mode while suspended, a character that matches the first resume register clears `tx_suspend` and is not written. A suspend character received while suspended is written like data.
- R5: In double mode (`fc_mode`=2), the pair first-suspend then second-suspend sets `tx_suspend`, and while suspended the pair first-resume then second-resume clears it. Neither character of a completed pair is written.
- R6: In double mode, when the character after a held one does not complete the pair, the held character is written in the cycle after the second `rx_valid`, and the second character is written one cycle later. This requires `rx_valid` pulses to be at least two cycles apart.
- R7: In double mode, a second character that fails to complete the pair but matches the first character of the pair is held as the start of a new pair rather than written.
- R8: `flag` goes to 1 on a suspend match and to 0 on a resume match. A `stat_rd` pulse clears it unless a match occurs in the same cycle. `irq` is `flag` gated by `irq_en`.
- R9: Comparison uses the low 5, 6, 7 or 8 bits for `wlen` = 0, 1, 2 or 3 respectively.
- R10: In special mode (`fc_mode`=3), every character is written. A match with the second suspend register sets `flag`, and `tx_suspend` does not change.
- R11: In off mode (`fc_mode`=0), every character is written, and `tx_suspend` and `flag` are unaffected by the character.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | X-register write strobe |
| cfg_addr | input | 2 | X-register select |
| cfg_wdata | input | 8 | X-register write data |
| fc_mode | input | 2 | 0 off, 1 single, 2 double, 3 special |
| wlen | input | 2 | Word length select |
| irq_en | input | 1 | Interrupt enable for the flag |
| stat_rd | input | 1 | Status read pulse, clears the flag |
| rx_valid | input | 1 | Received character strobe |
| rx_char | input | 8 | Received character |
| fifo_we | output | 1 | Write enable toward the receive FIFO |
| fifo_data | output | 8 | Character toward the receive FIFO |
| tx_suspend | output | 1 | Transmit suspend request |
| flag | output | 1 | Flow-control or special-character status |
| irq | output | 1 | Interrupt request |

## Verification
The matcher is driven with the following streams:
- plain data;
- exact suspend and resume characters, in single and double mode;
- a broken pair followed by data;
- a broken pair whose second character restarts the pair.

Together these separate correct consumption from correct release order and from re-evaluation of the second character. One character is sent whose low five bits equal a suspend value but whose upper bits do not. Sending it under both 5-bit and 8-bit word lengths shows that the mask is applied. The same suspend-looking bytes are also sent in special and off modes, and while already suspended, to confirm that they pass through without affecting the suspend request.

// File: rtl/xfc_pkg.sv
package xfc_pkg;

    localparam int CHAR_W   = 8;
    localparam int XR_NUM   = 4;
    localparam int XR_AW    = $clog2(XR_NUM);
    localparam int MIN_BITS = 5;

    localparam int XR_XON1  = 0;
    localparam int XR_XON2  = 1;
    localparam int XR_XOFF1 = 2;
    localparam int XR_XOFF2 = 3;

    typedef enum logic [1:0] {
        FC_OFF     = 2'd0,
        FC_SINGLE  = 2'd1,
        FC_DOUBLE  = 2'd2,
        FC_SPECIAL = 2'd3
    } fc_mode_e;

    typedef struct packed {
        logic              valid;
        logic [CHAR_W-1:0] data;
    } char_t;

    // Keep the low MIN_BITS + wl bits of a character.
    function automatic logic [CHAR_W-1:0] len_mask(input logic [1:0] wl);
        logic [CHAR_W-1:0] m;
        for (int i = 0; i < CHAR_W; i++) begin
            m[i] = (i < MIN_BITS + int'(wl));
        end
        return m;
    endfunction

endpackage

// File: rtl/xfc_xregs.sv
module xfc_xregs
    import xfc_pkg::*;
#(
    parameter int CW = CHAR_W,
    parameter int N  = XR_NUM,
    localparam int AW = $clog2(N)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  we,
    input  logic [AW-1:0]         addr,
    input  logic [CW-1:0]         wdata,
    output logic [N-1:0][CW-1:0]  regs
);

    for (genvar g = 0; g < N; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                regs[g] <= '0;
            end else if (we && (addr == AW'(g))) begin
                regs[g] <= wdata;
            end
        end
    end

endmodule

// File: rtl/xfc_compare.sv
module xfc_compare
    import xfc_pkg::*;
#(
    parameter int CW = CHAR_W,
    parameter int N  = XR_NUM
) (
    input  logic [CW-1:0]         ch,
    input  logic [1:0]            wl,
    input  logic [N-1:0][CW-1:0]  regs,
    output logic [N-1:0]          hit
);

    logic [CW-1:0] mask;
    assign mask = len_mask(wl);

    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign hit[g] = ((ch ^ regs[g]) & mask) == '0;
    end

endmodule

// File: rtl/xfc_seq.sv
module xfc_seq
    import xfc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  fc_mode_e          mode,
    input  logic              rx_valid,
    input  logic [CHAR_W-1:0] rx_char,
    input  logic [XR_NUM-1:0] hit,
    input  logic              stat_rd,
    output char_t             out_q,
    output logic              susp_q,
    output logic              flag_q
);

    logic              held_q, held_n;
    logic [CHAR_W-1:0] held_c_q, held_c_n;
    logic              pend_q, pend_n;
    logic [CHAR_W-1:0] pend_c_q, pend_c_n;
    logic              susp_n, flag_n;
    char_t             out_n;
    logic              first_hit, second_hit, match;

    always_comb begin
        first_hit  = susp_q ? hit[XR_XON1] : hit[XR_XOFF1];
        second_hit = susp_q ? hit[XR_XON2] : hit[XR_XOFF2];
        held_n     = held_q;
        held_c_n   = held_c_q;
        pend_n     = 1'b0;
        pend_c_n   = pend_c_q;
        susp_n     = susp_q;
        flag_n     = flag_q;
        match      = 1'b0;
        out_n      = '0;
        if (pend_q) begin
            out_n = '{valid: 1'b1, data: pend_c_q};
        end
        if (rx_valid) begin
            unique case (mode)
                FC_SINGLE: begin
                    if (first_hit) begin
                        match  = 1'b1;
                        susp_n = ~susp_q;
                        flag_n = ~susp_q;
                    end else begin
                        out_n = '{valid: 1'b1, data: rx_char};
                    end
                end
                FC_DOUBLE: begin
                    if (held_q) begin
                        if (second_hit) begin
                            match  = 1'b1;
                            susp_n = ~susp_q;
                            flag_n = ~susp_q;
                            held_n = 1'b0;
                        end else begin
                            out_n = '{valid: 1'b1, data: held_c_q};
                            if (first_hit) begin
                                held_c_n = rx_char;
                            end else begin
                                held_n   = 1'b0;
                                pend_n   = 1'b1;
                                pend_c_n = rx_char;
                            end
                        end
                    end else if (first_hit) begin
                        held_n   = 1'b1;
                        held_c_n = rx_char;
                    end else begin
                        out_n = '{valid: 1'b1, data: rx_char};
                    end
                end
                FC_SPECIAL: begin
                    out_n = '{valid: 1'b1, data: rx_char};
                    if (hit[XR_XOFF2]) begin
                        match  = 1'b1;
                        flag_n = 1'b1;
                    end
                end
                default: begin
                    out_n = '{valid: 1'b1, data: rx_char};
                end
            endcase
        end
        if (stat_rd && !match) begin
            flag_n = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q   <= 1'b0;
            held_c_q <= '0;
            pend_q   <= 1'b0;
            pend_c_q <= '0;
            susp_q   <= 1'b0;
            flag_q   <= 1'b0;
            out_q    <= '0;
        end else begin
            held_q   <= held_n;
            held_c_q <= held_c_n;
            pend_q   <= pend_n;
            pend_c_q <= pend_c_n;
            susp_q   <= susp_n;
            flag_q   <= flag_n;
            out_q    <= out_n;
        end
    end

endmodule

// File: rtl/xonxoff_rx_matcher.sv
module xonxoff_rx_matcher
    import xfc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [XR_AW-1:0]  cfg_addr,
    input  logic [CHAR_W-1:0] cfg_wdata,
    input  logic [1:0]        fc_mode,
    input  logic [1:0]        wlen,
    input  logic              irq_en,
    input  logic              stat_rd,
    input  logic              rx_valid,
    input  logic [CHAR_W-1:0] rx_char,
    output logic              fifo_we,
    output logic [CHAR_W-1:0] fifo_data,
    output logic              tx_suspend,
    output logic              flag,
    output logic              irq
);

    logic [XR_NUM-1:0][CHAR_W-1:0] xr;
    logic [XR_NUM-1:0]             hit;
    char_t                         out_q;
    logic                          susp_q, flag_q;

    xfc_xregs #(.CW(CHAR_W), .N(XR_NUM)) u_xregs (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .addr  (cfg_addr),
        .wdata (cfg_wdata),
        .regs  (xr)
    );

    xfc_compare #(.CW(CHAR_W), .N(XR_NUM)) u_cmp (
        .ch   (rx_char),
        .wl   (wlen),
        .regs (xr),
        .hit  (hit)
    );

    xfc_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .mode     (fc_mode_e'(fc_mode)),
        .rx_valid (rx_valid),
        .rx_char  (rx_char),
        .hit      (hit),
        .stat_rd  (stat_rd),
        .out_q    (out_q),
        .susp_q   (susp_q),
        .flag_q   (flag_q)
    );

    assign fifo_we    = out_q.valid;
    assign fifo_data  = out_q.data;
    assign tx_suspend = susp_q;
    assign flag       = flag_q;
    assign irq        = flag_q & irq_en;

endmodule

// File: rtl/xonxoff_rx_matcher_chk.sv
module xonxoff_rx_matcher_chk (
    input logic       clk,
    input logic       rst,
    input logic [1:0] fc_mode,
    input logic       rx_valid,
    input logic [7:0] rx_char,
    input logic       fifo_we,
    input logic [7:0] fifo_data,
    input logic       tx_suspend,
    input logic       flag
);

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (!tx_suspend && !flag && !fifo_we)); // R1

    AST_SUSPEND_NEEDS_CHAR: assert property (@(posedge clk) disable iff (rst)
        (tx_suspend != $past(tx_suspend)) |->
            ($past(rx_valid) && ($past(fc_mode) == 2'd1 || $past(fc_mode) == 2'd2))); // R3

    AST_WRITE_NEEDS_CHAR: assert property (@(posedge clk) disable iff (rst)
        fifo_we |-> ($past(rx_valid) || $past(rx_valid, 2))); // R6

    AST_FLAG_RISE_ON_CHAR: assert property (@(posedge clk) disable iff (rst)
        $rose(flag) |-> $past(rx_valid)); // R8

    AST_SPECIAL_PASSES: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && fc_mode == 2'd3) |=>
            (fifo_we && fifo_data == $past(rx_char) && $stable(tx_suspend))); // R10

    AST_OFF_PASSES: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && fc_mode == 2'd0) |=>
            (fifo_we && fifo_data == $past(rx_char) && $stable(tx_suspend))); // R11

endmodule

bind xonxoff_rx_matcher xonxoff_rx_matcher_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .fc_mode    (fc_mode),
    .rx_valid   (rx_valid),
    .rx_char    (rx_char),
    .fifo_we    (fifo_we),
    .fifo_data  (fifo_data),
    .tx_suspend (tx_suspend),
    .flag       (flag)
);

// File: tb/xonxoff_rx_matcher_tb_top.sv
module xonxoff_rx_matcher_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_we = 1'b0;
    logic [1:0] cfg_addr = '0;
    logic [7:0] cfg_wdata = '0;
    logic [1:0] fc_mode = 2'd0;
    logic [1:0] wlen = 2'd3;
    logic       irq_en = 1'b0;
    logic       stat_rd = 1'b0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_char = '0;
    logic       fifo_we;
    logic [7:0] fifo_data;
    logic       tx_suspend;
    logic       flag;
    logic       irq;

    int n_chk = 0;
    int n_bad = 0;
    logic       we0, we1;
    logic [7:0] d0, d1;

    always #5 clk = ~clk;

    xonxoff_rx_matcher dut_i (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .fc_mode(fc_mode), .wlen(wlen),
        .irq_en(irq_en), .stat_rd(stat_rd), .rx_valid(rx_valid),
        .rx_char(rx_char), .fifo_we(fifo_we), .fifo_data(fifo_data),
        .tx_suspend(tx_suspend), .flag(flag), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic wr_x(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Drive one character; capture the outputs one and two cycles later.
    task automatic put_char(input logic [7:0] c, input logic rd);
        @(negedge clk);
        rx_valid = 1'b1; rx_char = c; stat_rd = rd;
        @(negedge clk);
        rx_valid = 1'b0; stat_rd = 1'b0;
        we0 = fifo_we; d0 = fifo_data;
        @(negedge clk);
        we1 = fifo_we; d1 = fifo_data;
        repeat (2) @(negedge clk);
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 suspend", tx_suspend, 0);
        check("R1 flag", flag, 0);
        check("R1 irq", irq, 0);
        check("R1 fifo_we", fifo_we, 0);
        fc_mode = 2'd1; wlen = 2'd3;
        put_char(8'h00, 1'b0);
        check("R1 zero xreg consumes 00", we0, 0);
        check("R1 zero xreg suspends", tx_suspend, 1);
    endtask

    task automatic t_single();
        do_reset();
        fc_mode = 2'd1; wlen = 2'd3; irq_en = 1'b1;
        wr_x(2'd2, 8'h13); wr_x(2'd0, 8'h11);
        put_char(8'h41, 1'b0);
        check("R3 data written", we0, 1);
        check("R3 data value", d0, 8'h41);
        check("R3 no suspend on data", tx_suspend, 0);
        put_char(8'h13, 1'b0);
        check("R3 suspend char consumed", we0, 0);
        check("R3 suspend set", tx_suspend, 1);
        check("R8 flag set", flag, 1);
        check("R8 irq enabled", irq, 1);
        irq_en = 1'b0; #1;
        check("R8 irq masked", irq, 0);
        put_char(8'h13, 1'b0);
        check("R4 suspend char while suspended written", we0, 1);
        check("R4 suspend char data", d0, 8'h13);
        put_char(8'h11, 1'b0);
        check("R4 resume consumed", we0, 0);
        check("R4 resume clears suspend", tx_suspend, 0);
        check("R8 flag cleared on resume", flag, 0);
    endtask

    task automatic t_flag_read();
        do_reset();
        fc_mode = 2'd1; wlen = 2'd3;
        wr_x(2'd2, 8'h13);
        put_char(8'h13, 1'b0);
        check("R8 flag set", flag, 1);
        @(negedge clk); stat_rd = 1'b1;
        @(negedge clk); stat_rd = 1'b0;
        check("R8 read clears flag", flag, 0);
        check("R8 read keeps suspend", tx_suspend, 1);
    endtask

    task automatic t_double();
        do_reset();
        fc_mode = 2'd2; wlen = 2'd3;
        wr_x(2'd2, 8'h13); wr_x(2'd3, 8'h14);
        wr_x(2'd0, 8'h11); wr_x(2'd1, 8'h12);
        put_char(8'h13, 1'b0);
        check("R5 first held", we0 | we1, 0);
        check("R5 no suspend after first", tx_suspend, 0);
        put_char(8'h14, 1'b0);
        check("R5 pair consumed", we0 | we1, 0);
        check("R5 pair suspends", tx_suspend, 1);
        put_char(8'h11, 1'b0);
        check("R5 resume first held", we0 | we1, 0);
        put_char(8'h12, 1'b0);
        check("R5 resume pair consumed", we0 | we1, 0);
        check("R5 resume pair releases", tx_suspend, 0);
        // broken pair
        put_char(8'h13, 1'b0);
        put_char(8'h41, 1'b0);
        check("R6 held released first", we0, 1);
        check("R6 held value", d0, 8'h13);
        check("R6 second written next", we1, 1);
        check("R6 second value", d1, 8'h41);
        check("R6 no suspend", tx_suspend, 0);
        // re-evaluation
        put_char(8'h13, 1'b0);
        put_char(8'h13, 1'b0);
        check("R7 old held released", we0, 1);
        check("R7 old held value", d0, 8'h13);
        check("R7 new first held", we1, 0);
        put_char(8'h14, 1'b0);
        check("R7 restarted pair consumed", we0 | we1, 0);
        check("R7 restarted pair suspends", tx_suspend, 1);
    endtask

    task automatic t_wlen();
        do_reset();
        fc_mode = 2'd1; wlen = 2'd3;
        wr_x(2'd2, 8'h13);
        put_char(8'hF3, 1'b0);
        check("R9 8-bit no match written", we0, 1);
        check("R9 8-bit no suspend", tx_suspend, 0);
        wlen = 2'd0;
        put_char(8'hF3, 1'b0);
        check("R9 5-bit match consumed", we0, 0);
        check("R9 5-bit match suspends", tx_suspend, 1);
    endtask

    task automatic t_special();
        do_reset();
        fc_mode = 2'd3; wlen = 2'd3;
        wr_x(2'd3, 8'h7E); wr_x(2'd2, 8'h13);
        put_char(8'h13, 1'b0);
        check("R10 suspend char passes", we0, 1);
        check("R10 no suspend", tx_suspend, 0);
        check("R10 no flag on other", flag, 0);
        put_char(8'h7E, 1'b1);
        check("R10 special written", we0, 1);
        check("R10 special value", d0, 8'h7E);
        check("R10 flag set despite read", flag, 1);
        check("R10 no suspend on special", tx_suspend, 0);
    endtask

    task automatic t_off();
        do_reset();
        fc_mode = 2'd0; wlen = 2'd3;
        wr_x(2'd2, 8'h13);
        put_char(8'h13, 1'b0);
        check("R11 written", we0, 1);
        check("R11 value", d0, 8'h13);
        check("R11 no suspend", tx_suspend, 0);
        check("R11 no flag", flag, 0);
    endtask

    task automatic t_addr();
        do_reset();
        fc_mode = 2'd1; wlen = 2'd3;
        wr_x(2'd3, 8'h22);          // second suspend must not act in single mode
        put_char(8'h22, 1'b0);
        check("R2 addr 3 not first suspend", we0, 1);
        wr_x(2'd2, 8'h22);
        put_char(8'h22, 1'b0);
        check("R2 addr 2 is first suspend", tx_suspend, 1);
    endtask

    initial begin
        t_reset();
        t_single();
        t_flag_read();
        t_double();
        t_wlen();
        t_special();
        t_off();
        t_addr();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule